// File: doc/BRIEF.md
# Microcontroller Power Mode Controller

This block moves a small 8-bit microcontroller between three operating modes: run, idle and deep sleep. Software sets a mode request bit with a one-cycle write pulse. At the next machine-cycle boundary the controller switches mode and updates a registered bank of clock-gate enables. The bank covers the core clock, the PLL, the oscillator, the peripheral clock and the interval timer clock, and it also holds the three-state control for the DAC outputs. In idle only the core clock stops. In deep sleep the core, PLL and peripheral clocks stop and the DAC outputs float. The oscillator keeps running or stops according to a software bit. The interval timer, which runs straight from the oscillator, may keep counting.

The controller watches the interrupt request lines and their enable bits. Idle ends on any enabled request. Deep sleep ends only on three sources, each under its own permission: the interval timer, the serial (I2C/SPI) interrupt and the external INT0 line. When the block wakes, it stores a one-hot code of the waking source, and this code stays until the core acknowledges it. The block also flags software that enters deep sleep while INT0 is active, or while INT0 becomes active in the short guard window that follows.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, mode_o is 00 (run), core_clk_en, pll_en, osc_en, periph_clk_en and tic_clk_en are 1, dac_hiz is 0, wake_src is all zero and int0_viol is 0.
- R2: A pulse on req_idle_set in run mode moves mode_o to 01 (idle) at the next machine-cycle boundary, with core_clk_en 0 while pll_en, osc_en and periph_clk_en stay 1 and dac_hiz stays 0.
- R3: Idle returns to run at the first boundary where some irq_req bit is set together with its irq_en bit; a request whose irq_en bit is clear has no effect on the mode.
- R4: A pulse on req_pd_set in run mode moves mode_o to 10 (deep sleep) at the next boundary, with core_clk_en, pll_en and periph_clk_en at 0 and dac_hiz at 1; osc_en equals the inverse of osc_pd_bit as it stood at that boundary.
- R5: tic_clk_en equals tic_run AND the oscillator-running state, both taken at the latest boundary, so the timer clock stops in deep sleep when osc_pd_bit is set.
- R6: Deep sleep ends at a boundary only on an enabled request from source index 1 (interval timer), from index 2 (serial) when ser_wake_en is 1, or from index 0 (INT0) when int0_wake_en is 1; requests on any other index never end deep sleep.
- R7: When both requests are pending at a boundary, deep sleep takes precedence over idle.
- R8: On wake-up, wake_src holds a one-hot code of the waking source (bit i for source index i, the lowest waking index wins). The code stays until a wake_ack pulse, and it reads zero one cycle after that pulse.
- R9: mode_o and every clock enable change only on the clock edge that ends a cycle in which mc_boundary is 1 (outside reset), and mc_boundary is 1 for one cycle in every CLKS_PER_MC.
- R10: int0_viol is set, one cycle later, when irq_req[0] (INT0 active) is 1 in the cycle of req_pd_set or before two further machine-cycle boundaries have passed. The flag then stays set until reset.
- R11: Reset asserted in any mode returns the block to the R1 state at once and clears pending mode requests, so the block stays in run after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_idle_set | input | 1 | One-cycle write pulse setting the idle request bit |
| req_pd_set | input | 1 | One-cycle write pulse setting the deep-sleep request bit |
| osc_pd_bit | input | 1 | 1 stops the oscillator in deep sleep |
| tic_run | input | 1 | Interval timer enabled |
| ser_wake_en | input | 1 | Serial interrupt may end deep sleep |
| int0_wake_en | input | 1 | INT0 interrupt may end deep sleep |
| irq_req | input | NSRC | Interrupt requests; index 0 INT0 (1 = line active), 1 interval timer, 2 serial |
| irq_en | input | NSRC | Interrupt enable bits |
| wake_ack | input | 1 | Core acknowledges the recorded wake source |
| mc_boundary | output | 1 | One-cycle machine-cycle boundary strobe |
| mode_o | output | 2 | Current mode: 00 run, 01 idle, 10 deep sleep |
| core_clk_en | output | 1 | Core clock gate enable |
| pll_en | output | 1 | PLL enable |
| osc_en | output | 1 | Oscillator enable |
| periph_clk_en | output | 1 | Peripheral clock gate enable |
| tic_clk_en | output | 1 | Interval timer clock enable |
| dac_hiz | output | 1 | 1 places DAC outputs in high impedance |
| wake_src | output | NSRC | One-hot code of the source that ended the last low-power mode |
| int0_viol | output | 1 | Sticky flag: INT0 active in the deep-sleep entry window |

## Verification
Mode and clock-enable changes land on the clock edge that ends the cycle showing mc_boundary. The bench samples on falling edges, so it waits until mc_boundary reads 1 and then checks one falling edge later. A request pulse is released before that wait starts, because the pending bit is registered one edge after the pulse. The violation flag and the cleared wake code are due one edge after their causes and are checked at the next falling edge. A monitor compares mode and enables between consecutive falling edges and counts any change that did not follow a boundary.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [1:0] {
    PM_RUN  = 2'b00,
    PM_IDLE = 2'b01,
    PM_DOWN = 2'b10
  } pm_mode_e;

  typedef struct packed {
    logic core;
    logic pll;
    logic osc;
    logic periph;
    logic tic;
    logic dac_hiz;
  } clk_ctl_t;

  localparam int SRC_INT0 = 0;
  localparam int SRC_TIC  = 1;
  localparam int SRC_SER  = 2;

  localparam clk_ctl_t CTL_RESET = '{core: 1'b1, pll: 1'b1, osc: 1'b1,
                                      periph: 1'b1, tic: 1'b1, dac_hiz: 1'b0};

  // Clock-gate set for a mode; osc_off only matters in deep sleep.
  function automatic clk_ctl_t decode_ctl(pm_mode_e m, logic osc_off, logic tic_on);
    clk_ctl_t c;
    c = CTL_RESET;
    c.tic = tic_on;
    case (m)
      PM_IDLE: c.core = 1'b0;
      PM_DOWN: begin
        c.core    = 1'b0;
        c.pll     = 1'b0;
        c.periph  = 1'b0;
        c.osc     = ~osc_off;
        c.tic     = tic_on & ~osc_off;
        c.dac_hiz = 1'b1;
      end
      default: ;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/pmc_rst_sync.sv
module pmc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_a,
  output logic rst_n_s
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_a) begin
    if (!rst_n_a) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_s = sync_q[STAGES-1];
endmodule

// File: rtl/pmc_mc_timer.sv
module pmc_mc_timer #(
  parameter int CLKS_PER_MC = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (CLKS_PER_MC > 1) ? $clog2(CLKS_PER_MC) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLKS_PER_MC - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q == LAST);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  generate
    if (CLKS_PER_MC > 1) begin : g_spacing
      assert_tick_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/pmc_wake_sel.sv
module pmc_wake_sel
  import pmc_pkg::*;
#(
  parameter int NSRC = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_req,
  input  logic [NSRC-1:0] irq_en,
  input  logic            ser_wake_en,
  input  logic            int0_wake_en,
  input  logic            in_down,
  input  logic            capture,
  input  logic            ack,
  output logic            wake_any,
  output logic [NSRC-1:0] wake_src
);
  logic [NSRC-1:0] pd_mask, armed, first;
  logic [NSRC-1:0] src_q, src_d;
  logic            found;

  // Per-source permission to end deep sleep.
  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_mask
      if (i == SRC_INT0) begin : g_int0
        assign pd_mask[i] = int0_wake_en;
      end else if (i == SRC_TIC) begin : g_tic
        assign pd_mask[i] = 1'b1;
      end else if (i == SRC_SER) begin : g_ser
        assign pd_mask[i] = ser_wake_en;
      end else begin : g_none
        assign pd_mask[i] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    armed    = irq_req & irq_en & (in_down ? pd_mask : {NSRC{1'b1}});
    wake_any = |armed;
    first    = '0;
    found    = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (armed[i] && !found) begin
        first[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  always_comb begin
    src_d = src_q;
    if (capture)  src_d = first;
    else if (ack) src_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= '0;
    else        src_q <= src_d;
  end

  assign wake_src = src_q;

  assert_src_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_q));
  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !capture) |=> (src_q == '0));
  assert_pd_other_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_down && !(|(irq_req & irq_en & pd_mask))) |-> !wake_any);
endmodule

// File: rtl/pmc_int0_guard.sv
module pmc_int0_guard #(
  parameter int INT0_GUARD_MC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pd_req,
  input  logic int0_act,
  output logic viol
);
  localparam int GW = $clog2(INT0_GUARD_MC + 1);
  localparam logic [GW-1:0] GUARD = GW'(INT0_GUARD_MC);

  logic [GW-1:0] win_q, win_d;
  logic          viol_q, viol_d;
  logic          open;

  always_comb begin
    open  = pd_req | (win_q != '0);
    win_d = win_q;
    if (pd_req)                    win_d = GUARD;
    else if (tick && win_q != '0)  win_d = win_q - 1'b1;
    viol_d = viol_q | (open & int0_act);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      viol_q <= 1'b0;
    end else begin
      win_q  <= win_d;
      viol_q <= viol_d;
    end
  end

  assign viol = viol_q;

  assert_viol_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    viol_q |=> viol_q);
  assert_viol_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(viol_q) |-> $past(int0_act));
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int NSRC          = 5,
  parameter int CLKS_PER_MC   = 4,
  parameter int INT0_GUARD_MC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_idle_set,
  input  logic            req_pd_set,
  input  logic            osc_pd_bit,
  input  logic            tic_run,
  input  logic            ser_wake_en,
  input  logic            int0_wake_en,
  input  logic [NSRC-1:0] irq_req,
  input  logic [NSRC-1:0] irq_en,
  input  logic            wake_ack,
  output logic            mc_boundary,
  output logic [1:0]      mode_o,
  output logic            core_clk_en,
  output logic            pll_en,
  output logic            osc_en,
  output logic            periph_clk_en,
  output logic            tic_clk_en,
  output logic            dac_hiz,
  output logic [NSRC-1:0] wake_src,
  output logic            int0_viol
);
  logic     rst_s;
  logic     tick;
  pm_mode_e state_q, state_d;
  logic     pend_idle_q, pend_idle_d;
  logic     pend_pd_q, pend_pd_d;
  clk_ctl_t ctl_q, ctl_d;
  logic     wake_any;
  logic     leave;

  pmc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_a(rst_n), .rst_n_s(rst_s)
  );

  pmc_mc_timer #(.CLKS_PER_MC(CLKS_PER_MC)) u_mc (
    .clk(clk), .rst_n(rst_s), .tick(tick)
  );

  pmc_wake_sel #(.NSRC(NSRC)) u_wake (
    .clk(clk), .rst_n(rst_s),
    .irq_req(irq_req), .irq_en(irq_en),
    .ser_wake_en(ser_wake_en), .int0_wake_en(int0_wake_en),
    .in_down(state_q == PM_DOWN),
    .capture(leave), .ack(wake_ack),
    .wake_any(wake_any), .wake_src(wake_src)
  );

  pmc_int0_guard #(.INT0_GUARD_MC(INT0_GUARD_MC)) u_guard (
    .clk(clk), .rst_n(rst_s), .tick(tick),
    .pd_req(req_pd_set), .int0_act(irq_req[SRC_INT0]),
    .viol(int0_viol)
  );

  // Mode sequencing, evaluated only at machine-cycle boundaries.
  always_comb begin
    state_d = state_q;
    if (tick) begin
      case (state_q)
        PM_RUN: begin
          if (pend_pd_q)        state_d = PM_DOWN;
          else if (pend_idle_q) state_d = PM_IDLE;
        end
        PM_IDLE, PM_DOWN: begin
          if (wake_any) state_d = PM_RUN;
        end
        default: state_d = PM_RUN;
      endcase
    end
    leave = tick && (state_q != PM_RUN) && (state_d == PM_RUN);
  end

  // Software request bits: set in run mode, cleared on wake-up.
  always_comb begin
    pend_idle_d = pend_idle_q;
    pend_pd_d   = pend_pd_q;
    if (leave) begin
      pend_idle_d = 1'b0;
      pend_pd_d   = 1'b0;
    end else if (state_q == PM_RUN) begin
      pend_idle_d = pend_idle_q | req_idle_set;
      pend_pd_d   = pend_pd_q | req_pd_set;
    end
  end

  // Clock-gate bank is reloaded only at a boundary.
  always_comb begin
    ctl_d = ctl_q;
    if (tick) ctl_d = decode_ctl(state_d, osc_pd_bit, tic_run);
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      state_q     <= PM_RUN;
      pend_idle_q <= 1'b0;
      pend_pd_q   <= 1'b0;
      ctl_q       <= CTL_RESET;
    end else begin
      state_q     <= state_d;
      pend_idle_q <= pend_idle_d;
      pend_pd_q   <= pend_pd_d;
      ctl_q       <= ctl_d;
    end
  end

  assign mc_boundary   = tick;
  assign mode_o        = state_q;
  assign core_clk_en   = ctl_q.core;
  assign pll_en        = ctl_q.pll;
  assign osc_en        = ctl_q.osc;
  assign periph_clk_en = ctl_q.periph;
  assign tic_clk_en    = ctl_q.tic;
  assign dac_hiz       = ctl_q.dac_hiz;

  assert_mode_hold_R9: assert property (@(posedge clk) disable iff (!rst_s)
    !tick |=> $stable(state_q));
  assert_ctl_hold_R9: assert property (@(posedge clk) disable iff (!rst_s)
    !tick |=> $stable(ctl_q));
  assert_idle_gating_R2: assert property (@(posedge clk) disable iff (!rst_s)
    (state_q == PM_IDLE) |-> (!ctl_q.core && ctl_q.pll && ctl_q.periph && !ctl_q.dac_hiz));
  assert_down_gating_R4: assert property (@(posedge clk) disable iff (!rst_s)
    (state_q == PM_DOWN) |-> (!ctl_q.core && !ctl_q.pll && !ctl_q.periph && ctl_q.dac_hiz));
  assert_wake_recorded_R8: assert property (@(posedge clk) disable iff (!rst_s)
    leave |=> (wake_src != '0));
  assert_tic_needs_osc_R5: assert property (@(posedge clk) disable iff (!rst_s)
    ctl_q.tic |-> ctl_q.osc);
endmodule

// File: tb/tb_pwr_mode_ctrl.sv
module tb_pwr_mode_ctrl;
  localparam int NSRC = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic req_idle_set, req_pd_set, osc_pd_bit, tic_run, ser_wake_en, int0_wake_en;
  logic [NSRC-1:0] irq_req, irq_en;
  logic wake_ack;
  logic mc_boundary;
  logic [1:0] mode_o;
  logic core_clk_en, pll_en, osc_en, periph_clk_en, tic_clk_en, dac_hiz;
  logic [NSRC-1:0] wake_src;
  logic int0_viol;

  int n_checks = 0;
  int n_errors = 0;
  int r9_bad   = 0;
  logic       prev_rst = 1'b0;
  logic       prev_b   = 1'b0;
  logic [7:0] prev_vec = '0;

  always #2.5 clk = ~clk;

  pwr_mode_ctrl #(.NSRC(NSRC), .CLKS_PER_MC(4), .INT0_GUARD_MC(2)) dut (
    .clk(clk), .rst_n(rst_n), .req_idle_set(req_idle_set), .req_pd_set(req_pd_set),
    .osc_pd_bit(osc_pd_bit), .tic_run(tic_run), .ser_wake_en(ser_wake_en),
    .int0_wake_en(int0_wake_en), .irq_req(irq_req), .irq_en(irq_en),
    .wake_ack(wake_ack), .mc_boundary(mc_boundary), .mode_o(mode_o),
    .core_clk_en(core_clk_en), .pll_en(pll_en), .osc_en(osc_en),
    .periph_clk_en(periph_clk_en), .tic_clk_en(tic_clk_en), .dac_hiz(dac_hiz),
    .wake_src(wake_src), .int0_viol(int0_viol)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  // R9 monitor: mode and enables may only move after a boundary cycle.
  always @(negedge clk) begin
    if (rst_n && prev_rst && !prev_b &&
        ({mode_o, core_clk_en, pll_en, osc_en, periph_clk_en, tic_clk_en, dac_hiz} != prev_vec))
      r9_bad++;
    prev_vec = {mode_o, core_clk_en, pll_en, osc_en, periph_clk_en, tic_clk_en, dac_hiz};
    prev_b   = mc_boundary;
    prev_rst = rst_n;
  end

  task automatic wait_boundary();
    while (!mc_boundary) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_idle();
    @(negedge clk); req_idle_set = 1'b1;
    @(negedge clk); req_idle_set = 1'b0;
    wait_boundary();
  endtask

  task automatic pulse_pd();
    @(negedge clk); req_pd_set = 1'b1;
    @(negedge clk); req_pd_set = 1'b0;
    wait_boundary();
  endtask

  task automatic ack_and_clear();
    irq_req = '0;
    @(negedge clk); wake_ack = 1'b1;
    @(negedge clk); wake_ack = 1'b0;
    check("R8 wake_src cleared after ack", wake_src, 0);
  endtask

  task automatic do_reset();
    @(negedge clk); #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 mode", mode_o, 0);
    check("R1 enables core/pll/osc/periph/tic", {core_clk_en, pll_en, osc_en, periph_clk_en, tic_clk_en}, 5'h1f);
    check("R1 dac_hiz", dac_hiz, 0);
    check("R1 wake_src", wake_src, 0);
    check("R1 int0_viol", int0_viol, 0);
  endtask

  task automatic t_idle();
    pulse_idle();
    check("R2 idle mode", mode_o, 1);
    check("R2 idle gates", {core_clk_en, pll_en, osc_en, periph_clk_en, dac_hiz}, 5'b01110);
    irq_en = 5'b01111; irq_req = 5'b10000;
    wait_boundary();
    check("R3 disabled request keeps idle", mode_o, 1);
    irq_en = 5'b11111;
    wait_boundary();
    check("R3 enabled request resumes run", mode_o, 0);
    check("R3 core clock back", core_clk_en, 1);
    check("R8 idle wake code", wake_src, 5'b10000);
    ack_and_clear();
  endtask

  task automatic t_pd_osc_on();
    osc_pd_bit = 1'b0; tic_run = 1'b1; ser_wake_en = 1'b0; int0_wake_en = 1'b0;
    irq_en = 5'b11111;
    pulse_pd();
    check("R4 deep sleep mode", mode_o, 2);
    check("R4 deep sleep gates", {core_clk_en, pll_en, periph_clk_en, dac_hiz}, 4'b0001);
    check("R4 osc kept running", osc_en, 1);
    check("R5 timer clock kept", tic_clk_en, 1);
    irq_req = 5'b11000;
    wait_boundary(); wait_boundary();
    check("R6 other sources ignored", mode_o, 2);
    irq_req = 5'b00100;
    wait_boundary();
    check("R6 serial blocked without wake enable", mode_o, 2);
    ser_wake_en = 1'b1;
    wait_boundary();
    check("R6 serial wake", mode_o, 0);
    check("R8 serial wake code", wake_src, 5'b00100);
    ack_and_clear();
    ser_wake_en = 1'b0;
  endtask

  task automatic t_pd_osc_off();
    osc_pd_bit = 1'b1; tic_run = 1'b1;
    pulse_pd();
    check("R4 osc stopped", osc_en, 0);
    check("R5 timer clock stopped with osc", tic_clk_en, 0);
    irq_req = 5'b00010;
    wait_boundary();
    check("R6 timer wake", mode_o, 0);
    check("R4 osc restarted", osc_en, 1);
    check("R8 timer wake code", wake_src, 5'b00010);
    ack_and_clear();
    osc_pd_bit = 1'b0;
  endtask

  task automatic t_int0_wake();
    int0_wake_en = 1'b0; irq_en = 5'b11111;
    pulse_pd();
    wait_boundary(); wait_boundary();
    irq_req = 5'b00001;
    wait_boundary();
    check("R6 INT0 blocked without wake enable", mode_o, 2);
    int0_wake_en = 1'b1;
    wait_boundary();
    check("R6 INT0 wake", mode_o, 0);
    check("R8 INT0 wake code", wake_src, 5'b00001);
    check("R10 no flag outside window", int0_viol, 0);
    ack_and_clear();
    int0_wake_en = 1'b0;
  endtask

  task automatic t_both_and_prio();
    @(negedge clk); req_idle_set = 1'b1; req_pd_set = 1'b1;
    @(negedge clk); req_idle_set = 1'b0; req_pd_set = 1'b0;
    wait_boundary();
    check("R7 deep sleep wins", mode_o, 2);
    ser_wake_en = 1'b1;
    irq_req = 5'b00110;
    wait_boundary();
    check("R8 lowest index wins", wake_src, 5'b00010);
    ack_and_clear();
    ser_wake_en = 1'b0;
  endtask

  task automatic t_viol_and_reset();
    irq_en = 5'b11110; int0_wake_en = 1'b0;
    @(negedge clk); irq_req = 5'b00001; req_pd_set = 1'b1;
    @(negedge clk); req_pd_set = 1'b0;
    check("R10 violation flagged", int0_viol, 1);
    wait_boundary();
    check("R11 deep sleep before reset", mode_o, 2);
    @(negedge clk); #1 rst_n = 1'b0;
    #1;
    check("R11 reset forces run", mode_o, 0);
    check("R11 reset restores clocks", {core_clk_en, pll_en, osc_en, periph_clk_en, dac_hiz}, 5'b11110);
    check("R10 flag cleared by reset", int0_viol, 0);
    irq_req = '0;
    repeat (2) @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    wait_boundary(); wait_boundary();
    check("R11 request cleared by reset", mode_o, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; req_idle_set = 1'b0; req_pd_set = 1'b0; osc_pd_bit = 1'b0;
    tic_run = 1'b1; ser_wake_en = 1'b0; int0_wake_en = 1'b0;
    irq_req = '0; irq_en = '0; wake_ack = 1'b0;
    t_reset();
    t_idle();
    t_pd_osc_on();
    t_pd_osc_off();
    t_int0_wake();
    t_both_and_prio();
    t_viol_and_reset();
    check("R9 no change off boundary", r9_bad, 0);
    finish_run();
  end
endmodule